// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the serial front end of a byte-wide nonvolatile memory. It listens to an SPI bus in mode 0: it samples the data input on rising serial-clock edges and shifts its output on falling edges, most significant bit first. All four bus pins are brought into a faster system clock through two-stage synchronizers, and serial-clock edges are found from the synchronized samples. The serial output is presented as a data bit plus a separate output-enable, which the pad turns into a tristate driver.

The first byte after the select line falls is an opcode. Two commands set or clear the write-enable latch, one returns a status byte supplied by the status unit, and one hands a new status byte to that unit. The read command takes a two-byte address and then streams data from the internal synchronous RAM, stepping the address after each byte and wrapping from the top location back to zero. The write command takes a two-byte address and then presents each data byte, with its address, to the write unit as a strobe. The RAM takes the byte when the write unit grants it. The write address steps only within its page. An unknown opcode locks the frame out. While a program cycle is busy, every opcode except the status read is locked out in the same way. A pause input freezes a frame in mid-bit and releases it later without losing its place.

The array has 2^ADDR_W bytes. Full size is ADDR_W = 13, which gives 8192 locations. The default is 11, which keeps elaboration small.

Top module: `spi_mem_slave`

## Requirements
- R1: While the select input `ser_sel_n` is high, `ser_dout_en` is low and the data input has no effect. Each falling select edge starts a new frame whose first byte is an opcode, even when the previous frame was left incomplete.
- R2: Input bits are taken on rising `ser_clk` edges and output bits change on falling edges, most significant bit first.
- R3: Opcode 0x06 gives one single-cycle pulse on `wen_set`. Opcode 0x04 gives one single-cycle pulse on `wen_clr`. Either opcode ends the frame's input.
- R4: Opcode 0x05 shifts out `status_in`. The byte repeats for as long as the clock keeps running.
- R5: Opcode 0x01 takes one data byte and then gives one single-cycle pulse on `sr_wr`, with that byte on `sr_data`.
- R6: Opcode 0x03 is followed by a high and a low address byte. Bits of the 16-bit address at or above ADDR_W are ignored.
- R7: Read data streams while the select stays low. The address steps by one after each byte and wraps from 2^ADDR_W-1 to 0.
- R8: Opcode 0x02 is followed by two address bytes and then data bytes. Each data byte gives one `wr_stb` pulse carrying `wr_addr` and `wr_data`. The RAM stores the byte only when `wr_grant` is high. The low PAGE_W address bits step and wrap inside the page, and the upper bits stay fixed.
- R9: After any other opcode, no further input is accepted and `ser_dout_en` stays low until the next falling select edge.
- R10: With `ser_clk` low and the select low, pulling `ser_pause_n` low freezes the frame and turns `ser_dout_en` off. Clock edges during the pause are ignored. Raising `ser_pause_n` with the clock low resumes at the same bit.
- R11: While `prog_busy` is high at opcode completion, only 0x05 is executed. Every other opcode locks the frame out as in R9.
- R12: The data input is ignored during the read data phase.
- R13: At most one of the four request strobes is high in any cycle, and none lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock from the bus master |
| ser_din | input | 1 | Serial data from the master |
| ser_pause_n | input | 1 | Pause request, active low |
| ser_dout | output | 1 | Serial data to the master |
| ser_dout_en | output | 1 | Output-enable for ser_dout |
| prog_busy | input | 1 | Program cycle in progress |
| status_in | input | 8 | Status byte returned by opcode 0x05 |
| wr_grant | input | 1 | Write unit accepts the presented byte |
| wen_set | output | 1 | Request to set the write-enable latch |
| wen_clr | output | 1 | Request to clear the write-enable latch |
| sr_wr | output | 1 | Request to write the status byte |
| sr_data | output | 8 | New status byte |
| wr_stb | output | 1 | Write data byte strobe |
| wr_addr | output | ADDR_W | Address of the write byte |
| wr_data | output | 8 | Write data byte |

## Verification
A pin edge reaches the decision logic three system clocks after it happens: two synchronizer stages and one edge-detect stage. The output bit or request strobe follows one clock later, and `ser_dout_en` follows one clock after that. The bench holds each serial clock phase for eight system clocks. It samples the output at the end of the low phase, which is long after the falling edge that shifted it. It counts strobes continuously and reads the counts only after the frame has ended. Pause behaviour is checked several clocks after the pause pin moves, so that the enable has already dropped.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_pause_n,
  output logic              ser_dout,
  output logic              ser_dout_en,
  input  logic              prog_busy,
  input  logic [7:0]        status_in,
  input  logic              wr_grant,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              sr_wr,
  output logic [7:0]        sr_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] OP_WEN_ON  = 8'h06;
  localparam logic [7:0] OP_WEN_OFF = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_RD      = 8'h03;
  localparam logic [7:0] OP_WR      = 8'h02;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

  typedef enum logic [2:0] {S_OPC, S_AHI, S_ALO, S_RDAT, S_WDAT, S_STRD, S_STWR, S_OFF} st_t;

  logic [1:0] sel_sy, din_sy, pause_sy;
  logic [2:0] clk_sy;
  logic sel_q, din_q, pause_q, rise, fall;
  st_t st;
  logic [2:0] bcnt, ocnt;
  logic [7:0] sh_in, sh_out, byte_in, ram_q;
  logic [ADDR_W-9:0] ahi;
  logic [ADDR_W-1:0] addr;
  logic is_rd, held, talk, en_q;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_sy <= 2'b11; din_sy <= '0; pause_sy <= 2'b11; clk_sy <= '0;
    end else begin
      sel_sy   <= {sel_sy[0], ser_sel_n};
      din_sy   <= {din_sy[0], ser_din};
      pause_sy <= {pause_sy[0], ser_pause_n};
      clk_sy   <= {clk_sy[1:0], ser_clk};
    end

  assign sel_q   = sel_sy[1];
  assign din_q   = din_sy[1];
  assign pause_q = pause_sy[1];
  assign rise    = clk_sy[1] & ~clk_sy[2];
  assign fall    = ~clk_sy[1] & clk_sy[2];
  assign byte_in = {sh_in[6:0], din_q};
  assign ser_dout    = sh_out[7];
  assign ser_dout_en = en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OPC; bcnt <= '0; ocnt <= '0; sh_in <= '0; sh_out <= '0;
      ahi <= '0; addr <= '0; is_rd <= 1'b0; held <= 1'b0; talk <= 1'b0; en_q <= 1'b0;
      wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0; sr_data <= '0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0; wr_stb <= 1'b0;
      en_q <= ~sel_q & talk & ~held;
      if (sel_q) begin
        st <= S_OPC; bcnt <= '0; held <= 1'b0; talk <= 1'b0;
      end else begin
        if (!held && !clk_sy[1] && !pause_q) held <= 1'b1;
        else if (held && !clk_sy[1] && pause_q) held <= 1'b0;

        if (!held && rise && (st == S_OPC || st == S_AHI || st == S_ALO ||
                              st == S_WDAT || st == S_STWR)) begin
          sh_in <= byte_in;
          bcnt  <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            case (st)
              S_OPC: begin
                if (prog_busy && byte_in != OP_STAT_RD) st <= S_OFF;
                else case (byte_in)
                  OP_WEN_ON:  begin wen_set <= 1'b1; st <= S_OFF; end
                  OP_WEN_OFF: begin wen_clr <= 1'b1; st <= S_OFF; end
                  OP_STAT_RD: begin st <= S_STRD; ocnt <= '0; end
                  OP_STAT_WR: st <= S_STWR;
                  OP_RD:      begin st <= S_AHI; is_rd <= 1'b1; end
                  OP_WR:      begin st <= S_AHI; is_rd <= 1'b0; end
                  default:    st <= S_OFF;
                endcase
              end
              S_AHI: begin ahi <= byte_in[ADDR_W-9:0]; st <= S_ALO; end
              S_ALO: begin
                addr <= {ahi, byte_in};
                ocnt <= '0;
                st   <= is_rd ? S_RDAT : S_WDAT;
              end
              S_WDAT: begin
                wr_stb  <= 1'b1;
                wr_addr <= addr;
                wr_data <= byte_in;
                addr    <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_ONE};
              end
              S_STWR: begin sr_wr <= 1'b1; sr_data <= byte_in; st <= S_OFF; end
              default: st <= S_OFF;
            endcase
          end
        end

        if (!held && fall && (st == S_RDAT || st == S_STRD)) begin
          talk <= 1'b1;
          ocnt <= ocnt + 3'd1;
          if (ocnt == 3'd0) begin
            sh_out <= (st == S_RDAT) ? ram_q : status_in;
            if (st == S_RDAT) addr <= addr + 1'b1;
          end else begin
            sh_out <= {sh_out[6:0], 1'b0};
          end
        end
      end
    end

  always_ff @(posedge clk) begin
    if (wr_stb && wr_grant) mem[wr_addr] <= wr_data;
    ram_q <= mem[addr];
  end
endmodule

module spi_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_q,
  input logic held,
  input logic ser_dout,
  input logic ser_dout_en,
  input logic prog_busy,
  input logic wen_set,
  input logic wen_clr,
  input logic sr_wr,
  input logic wr_stb
);
  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> !ser_dout_en);
  // R10
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> !ser_dout_en);
  // R10
  pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(ser_dout));
  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wen_set, wen_clr, sr_wr, wr_stb}));
  // R13
  short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_set || wen_clr || sr_wr) |=> !(wen_set || wen_clr || sr_wr));
  // R11
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_set || wen_clr) |-> !$past(prog_busy));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .held(held), .ser_dout(ser_dout),
  .ser_dout_en(ser_dout_en), .prog_busy(prog_busy), .wen_set(wen_set),
  .wen_clr(wen_clr), .sr_wr(sr_wr), .wr_stb(wr_stb)
);

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;
  localparam int AW = 11;
  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sck = 0, din = 0, pause_n = 1, busy = 0, grant = 1;
  logic [7:0] stat = 8'h96;
  logic dout, dout_en, wset, wclr, srw, wstb;
  logic [7:0] srd, wdat;
  logic [AW-1:0] wadr;
  int checks = 0, fails = 0;
  int n_set = 0, n_clr = 0, n_sr = 0, n_wr = 0;
  logic any_oe;
  logic [7:0] rx, rx2;

  always #10 clk = ~clk;

  spi_mem_slave u_spi_mem_slave (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sck), .ser_din(din),
    .ser_pause_n(pause_n), .ser_dout(dout), .ser_dout_en(dout_en),
    .prog_busy(busy), .status_in(stat), .wr_grant(grant), .wen_set(wset),
    .wen_clr(wclr), .sr_wr(srw), .sr_data(srd), .wr_stb(wstb),
    .wr_addr(wadr), .wr_data(wdat));

  always @(posedge clk) begin
    if (wset) n_set++;
    if (wclr) n_clr++;
    if (srw)  n_sr++;
    if (wstb) n_wr++;
  end

  localparam logic [23:0] VEC [8] = '{
    24'h0005A1, 24'h0123B2, 24'hF9A0C3, 24'h0400D4,
    24'h02FFE5, 24'h0777F6, 24'h801007, 24'h055518};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    din = b;
    repeat (8) @(negedge clk);
    r = dout;
    if (dout_en) any_oe = 1;
    sck = 1;
    repeat (8) @(negedge clk);
    sck = 0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], r[i]);
  endtask

  task automatic sel_on;
    sel_n = 0; any_oe = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sel_off;
    repeat (4) @(negedge clk);
    sel_n = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] t;
    sel_on; spi_byte(8'h02, t); spi_byte(a[15:8], t); spi_byte(a[7:0], t);
    spi_byte(d, t); sel_off;
  endtask

  task automatic mem_read(input logic [15:0] a, output logic [7:0] d);
    logic [7:0] t;
    sel_on; spi_byte(8'h03, t); spi_byte(a[15:8], t); spi_byte(a[7:0], t);
    spi_byte(8'h00, d); sel_off;
  endtask

  initial begin
    logic [7:0] t;
    logic b;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 reset enable", dout_en, 0);
    chk("R13 reset strobes", n_set + n_clr + n_sr + n_wr, 0);

    // R8 / R6 / R2 vector table: write then read back
    foreach (VEC[i]) mem_write(VEC[i][23:8], VEC[i][7:0]);
    chk("R8 write strobes", n_wr, 8);
    foreach (VEC[i]) begin
      mem_read(VEC[i][23:8], rx);
      chk("R2 R8 readback", rx, VEC[i][7:0]);
    end
    mem_read(16'h01A0, rx);
    chk("R6 masked high bits", rx, 8'hC3);

    // R7 streaming with wrap
    mem_write(16'h07FF, 8'h5A);
    mem_write(16'h0000, 8'hA5);
    sel_on; spi_byte(8'h03, t); spi_byte(8'h07, t); spi_byte(8'hFF, t);
    spi_byte(8'h00, rx); spi_byte(8'h00, rx2); sel_off;
    chk("R7 top byte", rx, 8'h5A);
    chk("R7 wrap to zero", rx2, 8'hA5);

    // R8 page wrap
    mem_write(16'h0040, 8'h99);
    sel_on; spi_byte(8'h02, t); spi_byte(8'h00, t); spi_byte(8'h3F, t);
    spi_byte(8'h3C, t); spi_byte(8'h4D, t); sel_off;
    mem_read(16'h0020, rx); chk("R8 page wrap", rx, 8'h4D);
    mem_read(16'h003F, rx); chk("R8 page end", rx, 8'h3C);
    mem_read(16'h0040, rx); chk("R8 next page untouched", rx, 8'h99);

    // R8 grant low
    grant = 0; mem_write(16'h0005, 8'h00); grant = 1;
    mem_read(16'h0005, rx); chk("R8 no grant keeps data", rx, 8'hA1);

    // R3
    sel_on; spi_byte(8'h06, t); sel_off; chk("R3 set pulse", n_set, 1);
    sel_on; spi_byte(8'h04, t); spi_byte(8'h06, t); sel_off;
    chk("R3 clear pulse", n_clr, 1);
    chk("R3 input ends after opcode", n_set, 1);

    // R4
    sel_on; spi_byte(8'h05, t); spi_byte(8'h00, rx); spi_byte(8'h00, rx2); sel_off;
    chk("R4 status", rx, 8'h96);
    chk("R4 status repeat", rx2, 8'h96);

    // R5
    sel_on; spi_byte(8'h01, t); spi_byte(8'h0C, t); sel_off;
    chk("R5 status write pulse", n_sr, 1);
    chk("R5 status data", srd, 8'h0C);

    // R9 invalid opcode
    sel_on; spi_byte(8'hFF, t); spi_byte(8'h06, t); spi_byte(8'h00, t); sel_off;
    chk("R9 lockout no strobe", n_set, 1);
    chk("R9 lockout output off", any_oe, 0);

    // R1 restart after incomplete frame, data ignored while deselected
    sel_on; spi_byte(8'h03, t); sel_off;
    for (int i = 0; i < 8; i++) spi_bit(i[0], b);
    sel_on; spi_byte(8'h06, t); sel_off;
    chk("R1 restart opcode", n_set, 2);

    // R11 busy gating
    busy = 1;
    sel_on; spi_byte(8'h06, t); sel_off;
    chk("R11 busy blocks set", n_set, 2);
    sel_on; spi_byte(8'h05, t); spi_byte(8'h00, rx); sel_off;
    chk("R11 status while busy", rx, 8'h96);
    busy = 0;

    // R12 input ignored while reading
    sel_on; spi_byte(8'h03, t); spi_byte(8'h04, t); spi_byte(8'h00, t);
    spi_byte(8'h06, rx); spi_byte(8'h01, rx2); sel_off;
    chk("R12 read data", rx, 8'hD4);
    chk("R12 no strobe", n_set + n_sr, 3);

    // R10 pause mid-byte
    sel_on; spi_byte(8'h03, t); spi_byte(8'h01, t); spi_byte(8'h23, t);
    for (int i = 7; i >= 4; i--) spi_bit(1'b0, rx[i]);
    pause_n = 0;
    repeat (8) @(negedge clk);
    chk("R10 output off in pause", dout_en, 0);
    for (int i = 0; i < 3; i++) begin
      sck = 1; repeat (8) @(negedge clk);
      sck = 0; repeat (8) @(negedge clk);
    end
    pause_n = 1;
    repeat (8) @(negedge clk);
    for (int i = 3; i >= 0; i--) spi_bit(1'b0, rx[i]);
    sel_off;
    chk("R10 resume same bit", rx, 8'hB2);
    chk("R13 total writes", n_wr, 14);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule